// File: doc/BRIEF.md
# Pipelined Decision-Tree Packet Classifier

This block classifies packet headers by descending a binary decision tree, with exactly one tree level handled by each pipeline stage. Every stage owns a small node memory that holds only the nodes at its depth. A header enters the first stage at node 0. Each stage reads the node addressed by the incoming index. The node's selector picks one 16-bit field of the full header, and that field is compared with the node's threshold. The comparison chooses the child slot in the next level's memory. When a stage meets a leaf, the leaf's rule number is latched into the travelling token, and a sticky found bit protects it through every later stage.

Each node memory has two read ports, so two independent lanes share one tree image and the block accepts two headers per clock. A single write port, steered by a stage selector, loads node words before or between lookups. The tree is built offline by software. The block only walks it.

Top module: `dtree_lookup_pipe`

## Requirements
- R1: After synchronous reset, both lanes' output valid signals are low until a header that entered after reset has crossed the pipeline.
- R2: A header accepted with its lane valid high on one clock edge appears at that lane's outputs after exactly 2*NUM_STAGES clock edges, counting the accepting edge. The output header equals the input header. A new header may enter on every clock.
- R3: A node word is {leaf[30], selector[29:26], threshold[25:10], pointer[9:0]}. For a leaf, the pointer is the rule number. For an inner node, it is the base index of the children in the next stage's memory.
- R4: At an inner node, a field value less than or equal to the threshold continues at index base. A larger value continues at base+1.
- R5: The selector value k picks header bits [16*k+15 : 16*k], so any of the 16 header fields can be tested at any level.
- R6: A leaf reached in any stage makes the lookup report a match with that leaf's pointer as the rule number.
- R7: Once a match has been found, later stages leave the rule number unchanged, whatever their memories hold at address 0.
- R8: A lookup that reaches no leaf by the last stage reports no match, and the rule number is all ones (0x3FF).
- R9: The two lanes are independent. Headers applied on both lanes in the same cycle are each classified correctly against the shared tree.
- R10: A write with the write enable high stores the word at the given address of the stage chosen by the write stage selector only. Lookups after the write use the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Node write strobe |
| wr_stage | input | 2 | Target stage of the write |
| wr_addr | input | 6 | Node address within the stage |
| wr_data | input | 31 | Node word |
| a_in_valid | input | 1 | Lane A header valid |
| a_in_hdr | input | 256 | Lane A header (16 fields of 16 bits) |
| b_in_valid | input | 1 | Lane B header valid |
| b_in_hdr | input | 256 | Lane B header |
| a_out_valid | output | 1 | Lane A result valid |
| a_out_match | output | 1 | Lane A leaf found |
| a_out_rule | output | 10 | Lane A rule number, all ones on no match |
| a_out_hdr | output | 256 | Lane A header leaving the pipeline |
| b_out_valid | output | 1 | Lane B result valid |
| b_out_match | output | 1 | Lane B leaf found |
| b_out_rule | output | 10 | Lane B rule number |
| b_out_hdr | output | 256 | Lane B header leaving the pipeline |

## Verification
The lane assertions assume that the node memories hold a well-formed tree on every path that a live header can take. They also assume that inputs stay idle during reset, so the first tokens after reset are bubbles. The stimulus loads every node that its headers can reach before it sends any lookup, and it rewrites nodes only while the pipeline is empty. It also places decoy leaves at address 0 of the deeper stages, so that a broken sticky-found path shows up as a wrong rule number and not as an unnoticed match.

// File: rtl/dtree_pkg.sv
package dtree_pkg;

    localparam int FIELD_W    = 16;
    localparam int SEL_W      = 4;
    localparam int NUM_FIELDS = 1 << SEL_W;
    localparam int HDR_W      = FIELD_W * NUM_FIELDS;
    localparam int RULE_W     = 10;
    localparam int PTR_W      = RULE_W;
    localparam int NODE_W     = 1 + SEL_W + FIELD_W + PTR_W;

    typedef struct packed {
        logic               leaf;
        logic [SEL_W-1:0]   sel;
        logic [FIELD_W-1:0] thr;
        logic [PTR_W-1:0]   ptr;
    } node_t;

    typedef struct packed {
        logic               valid;
        logic               found;
        logic [RULE_W-1:0]  rule;
        logic [PTR_W-1:0]   idx;
        logic [HDR_W-1:0]   hdr;
    } token_t;

    function automatic logic [FIELD_W-1:0] pick_field(
        input logic [HDR_W-1:0] hdr,
        input logic [SEL_W-1:0] sel
    );
        return hdr[sel*FIELD_W +: FIELD_W];
    endfunction

endpackage

// File: rtl/dtree_node_mem.sv
module dtree_node_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 31
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr0,
    input  logic [ADDR_W-1:0] raddr1,
    output logic [DATA_W-1:0] rdata0,
    output logic [DATA_W-1:0] rdata1
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
        rdata0 <= store[raddr0];
        rdata1 <= store[raddr1];
    end

endmodule

// File: rtl/dtree_lane_step.sv
module dtree_lane_step
    import dtree_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  token_t            tok_in,
    output logic [ADDR_W-1:0] rd_addr,
    input  node_t             node_q,
    output token_t            tok_out
);
    token_t             tok_a;
    token_t             nxt;
    logic               go_right;
    logic [1:0]         warm;

    // a token already resolved reads a fixed slot and ignores it
    assign rd_addr = tok_in.found ? '0 : tok_in.idx[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) tok_a <= '0;
        else     tok_a <= tok_in;
    end

    assign go_right = pick_field(tok_a.hdr, node_q.sel) > node_q.thr;

    always_comb begin
        nxt = tok_a;
        if (!tok_a.found) begin
            if (node_q.leaf) begin
                nxt.found = 1'b1;
                nxt.rule  = node_q.ptr;
            end else begin
                nxt.idx = node_q.ptr + {{(PTR_W-1){1'b0}}, go_right};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tok_out <= '0;
        else     tok_out <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst)               warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    // R2
    valid_pipe_chk: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2) |-> (tok_out.valid == $past(tok_in.valid, 2)));

    // R7
    sticky_found_chk: assert property (@(posedge clk) disable iff (rst)
        ((warm == 2'd2) && $past(tok_in.valid && tok_in.found, 2))
        |-> (tok_out.found && tok_out.rule == $past(tok_in.rule, 2)));

    // R6
    leaf_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (tok_a.valid && !tok_a.found && node_q.leaf)
        |=> (tok_out.found && tok_out.rule == $past(node_q.ptr)));

    // R8
    unfound_rule_chk: assert property (@(posedge clk) disable iff (rst)
        (tok_out.valid && !tok_out.found) |-> (tok_out.rule == '1));

endmodule

// File: rtl/dtree_stage.sv
module dtree_stage
    import dtree_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [NODE_W-1:0] wdata,
    input  token_t            tok_in_a,
    input  token_t            tok_in_b,
    output token_t            tok_out_a,
    output token_t            tok_out_b
);
    logic [ADDR_W-1:0] addr_a, addr_b;
    logic [NODE_W-1:0] word_a, word_b;

    dtree_node_mem #(.ADDR_W(ADDR_W), .DATA_W(NODE_W)) mem_i (
        .clk    (clk),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wdata),
        .raddr0 (addr_a),
        .raddr1 (addr_b),
        .rdata0 (word_a),
        .rdata1 (word_b)
    );

    dtree_lane_step #(.ADDR_W(ADDR_W)) lane_a_i (
        .clk     (clk),
        .rst     (rst),
        .tok_in  (tok_in_a),
        .rd_addr (addr_a),
        .node_q  (node_t'(word_a)),
        .tok_out (tok_out_a)
    );

    dtree_lane_step #(.ADDR_W(ADDR_W)) lane_b_i (
        .clk     (clk),
        .rst     (rst),
        .tok_in  (tok_in_b),
        .rd_addr (addr_b),
        .node_q  (node_t'(word_b)),
        .tok_out (tok_out_b)
    );

endmodule

// File: rtl/dtree_lookup_pipe.sv
module dtree_lookup_pipe
    import dtree_pkg::*;
#(
    parameter int NUM_STAGES = 4,
    parameter int ADDR_W     = 6,
    localparam int STG_W     = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [STG_W-1:0]      wr_stage,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [NODE_W-1:0]     wr_data,
    input  logic                  a_in_valid,
    input  logic [HDR_W-1:0]      a_in_hdr,
    input  logic                  b_in_valid,
    input  logic [HDR_W-1:0]      b_in_hdr,
    output logic                  a_out_valid,
    output logic                  a_out_match,
    output logic [RULE_W-1:0]     a_out_rule,
    output logic [HDR_W-1:0]      a_out_hdr,
    output logic                  b_out_valid,
    output logic                  b_out_match,
    output logic [RULE_W-1:0]     b_out_rule,
    output logic [HDR_W-1:0]      b_out_hdr
);
    token_t chain_a [NUM_STAGES+1];
    token_t chain_b [NUM_STAGES+1];

    assign chain_a[0] = '{valid: a_in_valid, found: 1'b0, rule: '1, idx: '0, hdr: a_in_hdr};
    assign chain_b[0] = '{valid: b_in_valid, found: 1'b0, rule: '1, idx: '0, hdr: b_in_hdr};

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        logic stage_we;
        assign stage_we = wr_en && (wr_stage == STG_W'(s));

        dtree_stage #(.ADDR_W(ADDR_W)) stage_i (
            .clk       (clk),
            .rst       (rst),
            .we        (stage_we),
            .waddr     (wr_addr),
            .wdata     (wr_data),
            .tok_in_a  (chain_a[s]),
            .tok_in_b  (chain_b[s]),
            .tok_out_a (chain_a[s+1]),
            .tok_out_b (chain_b[s+1])
        );
    end

    assign a_out_valid = chain_a[NUM_STAGES].valid;
    assign a_out_match = chain_a[NUM_STAGES].valid && chain_a[NUM_STAGES].found;
    assign a_out_rule  = chain_a[NUM_STAGES].found ? chain_a[NUM_STAGES].rule : '1;
    assign a_out_hdr   = chain_a[NUM_STAGES].hdr;

    assign b_out_valid = chain_b[NUM_STAGES].valid;
    assign b_out_match = chain_b[NUM_STAGES].valid && chain_b[NUM_STAGES].found;
    assign b_out_rule  = chain_b[NUM_STAGES].found ? chain_b[NUM_STAGES].rule : '1;
    assign b_out_hdr   = chain_b[NUM_STAGES].hdr;

endmodule

// File: tb/dtree_lookup_pipe_tb_top.sv
module dtree_lookup_pipe_tb_top;
    import dtree_pkg::*;

    localparam int NSTG = 4;
    localparam int AW   = 6;
    localparam int LAT  = 2 * NSTG;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_stage = '0;
    logic [AW-1:0]     wr_addr = '0;
    logic [NODE_W-1:0] wr_data = '0;
    logic              a_in_valid = 1'b0, b_in_valid = 1'b0;
    logic [HDR_W-1:0]  a_in_hdr = '0, b_in_hdr = '0;
    logic              a_out_valid, a_out_match, b_out_valid, b_out_match;
    logic [RULE_W-1:0] a_out_rule, b_out_rule;
    logic [HDR_W-1:0]  a_out_hdr, b_out_hdr;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    dtree_lookup_pipe #(.NUM_STAGES(NSTG), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_stage(wr_stage), .wr_addr(wr_addr), .wr_data(wr_data),
        .a_in_valid(a_in_valid), .a_in_hdr(a_in_hdr),
        .b_in_valid(b_in_valid), .b_in_hdr(b_in_hdr),
        .a_out_valid(a_out_valid), .a_out_match(a_out_match),
        .a_out_rule(a_out_rule), .a_out_hdr(a_out_hdr),
        .b_out_valid(b_out_valid), .b_out_match(b_out_match),
        .b_out_rule(b_out_rule), .b_out_hdr(b_out_hdr)
    );

    function automatic logic [HDR_W-1:0] mk_hdr(logic [15:0] f0, logic [15:0] f2, logic [15:0] f15);
        logic [HDR_W-1:0] h = '0;
        h[0*16 +: 16]  = f0;
        h[2*16 +: 16]  = f2;
        h[15*16 +: 16] = f15;
        return h;
    endfunction

    // R3 layout: {leaf, selector[3:0], threshold[15:0], pointer[9:0]}
    function automatic logic [NODE_W-1:0] mk_node(logic leaf, logic [3:0] sel,
                                                  logic [15:0] thr, logic [9:0] ptr);
        return {leaf, sel, thr, ptr};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load(logic [1:0] stg, logic [AW-1:0] addr, logic [NODE_W-1:0] word);
        @(negedge clk);
        wr_en = 1'b1; wr_stage = stg; wr_addr = addr; wr_data = word;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_tree();
        load(2'd0, 6'd0, mk_node(1'b0, 4'd2,  16'h1000, 10'd0));
        load(2'd1, 6'd0, mk_node(1'b1, 4'd0,  16'h0000, 10'd5));
        load(2'd1, 6'd1, mk_node(1'b0, 4'd0,  16'h0050, 10'd2));
        load(2'd2, 6'd0, mk_node(1'b1, 4'd0,  16'h0000, 10'd7));
        load(2'd2, 6'd2, mk_node(1'b0, 4'd15, 16'hFFFE, 10'd4));
        load(2'd2, 6'd3, mk_node(1'b1, 4'd0,  16'h0000, 10'h2A));
        load(2'd3, 6'd0, mk_node(1'b1, 4'd0,  16'h0000, 10'd9));
        load(2'd3, 6'd4, mk_node(1'b1, 4'd0,  16'h0000, 10'd100));
        load(2'd3, 6'd5, mk_node(1'b0, 4'd0,  16'h0000, 10'd0));
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        check("R1", "a_valid in reset", 32'(a_out_valid), 0);
        check("R1", "b_valid in reset", 32'(b_out_valid), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", "a_valid after reset", 32'(a_out_valid), 0);
        check("R1", "b_valid after reset", 32'(b_out_valid), 0);
    endtask

    task automatic run_a(string req, logic [HDR_W-1:0] h, logic exp_m, logic [9:0] exp_r);
        @(negedge clk);
        a_in_valid = 1'b1; a_in_hdr = h;
        @(negedge clk);
        a_in_valid = 1'b0;
        repeat (LAT - 2) @(negedge clk);
        check("R2", "valid one cycle early", 32'(a_out_valid), 0);
        @(negedge clk);
        check("R2", "valid at latency", 32'(a_out_valid), 1);
        check(req, "match", 32'(a_out_match), 32'(exp_m));
        check(req, "rule", 32'(a_out_rule), 32'(exp_r));
        check("R2", "header out", 32'(a_out_hdr == h), 1);
    endtask

    task automatic run_dual(logic [HDR_W-1:0] ha, logic [9:0] ra,
                            logic [HDR_W-1:0] hb, logic [9:0] rb);
        @(negedge clk);
        a_in_valid = 1'b1; a_in_hdr = ha;
        b_in_valid = 1'b1; b_in_hdr = hb;
        @(negedge clk);
        a_in_valid = 1'b0; b_in_valid = 1'b0;
        repeat (LAT - 1) @(negedge clk);
        check("R9", "a valid", 32'(a_out_valid), 1);
        check("R9", "b valid", 32'(b_out_valid), 1);
        check("R9", "a rule", 32'(a_out_rule), 32'(ra));
        check("R9", "b rule", 32'(b_out_rule), 32'(rb));
        check("R9", "b header", 32'(b_out_hdr == hb), 1);
    endtask

    task automatic run_stream();
        logic [HDR_W-1:0] hv [4];
        logic [9:0]       rv [4];
        hv[0] = mk_hdr(16'h0000, 16'h0001, 16'h0000); rv[0] = 10'd5;
        hv[1] = mk_hdr(16'h0010, 16'h2000, 16'h0001); rv[1] = 10'd100;
        hv[2] = mk_hdr(16'h9000, 16'h2000, 16'h0000); rv[2] = 10'h2A;
        hv[3] = mk_hdr(16'h0000, 16'h8000, 16'hFFFF); rv[3] = 10'h3FF;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            a_in_valid = 1'b1; a_in_hdr = hv[i];
        end
        @(negedge clk);
        a_in_valid = 1'b0;
        repeat (LAT - 4) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            if (i > 0) @(negedge clk);
            check("R2", "stream valid", 32'(a_out_valid), 1);
            check("R2", "stream rule", 32'(a_out_rule), 32'(rv[i]));
        end
        @(negedge clk);
        check("R2", "stream drained", 32'(a_out_valid), 0);
    endtask

    task automatic test_rewrite();
        load(2'd3, 6'd4, mk_node(1'b1, 4'd0, 16'h0000, 10'd200));
        run_a("R10", mk_hdr(16'h0050, 16'h1001, 16'hFFFE), 1'b1, 10'd200);
        run_a("R10", mk_hdr(16'h0051, 16'h1001, 16'h0000), 1'b1, 10'h2A);
        run_a("R10", mk_hdr(16'h0000, 16'h0000, 16'h0000), 1'b1, 10'd5);
    endtask

    initial begin
        test_reset();
        load_tree();
        // R6 R7: early leaf in stage 1, decoy leaves at address 0 further down
        run_a("R7", mk_hdr(16'h0000, 16'h0800, 16'h0000), 1'b1, 10'd5);
        // R4: equality goes to base
        run_a("R4", mk_hdr(16'h0000, 16'h1000, 16'h0000), 1'b1, 10'd5);
        // R4 R5 R6: equality at fields 0 and 15, leaf in last stage
        run_a("R5", mk_hdr(16'h0050, 16'h1001, 16'hFFFE), 1'b1, 10'd100);
        // R4: one above threshold goes to base+1
        run_a("R6", mk_hdr(16'h0051, 16'h1001, 16'h0000), 1'b1, 10'h2A);
        // R8: path ends on an inner node
        run_a("R8", mk_hdr(16'h0000, 16'hFFFF, 16'hFFFF), 1'b0, 10'h3FF);
        run_dual(mk_hdr(16'h0050, 16'h1001, 16'hFFFE), 10'd100,
                 mk_hdr(16'h0051, 16'h1001, 16'h0000), 10'h2A);
        run_stream();
        test_rewrite();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule